// File: doc/BRIEF.md
# Secure-Aware Interrupt Priority Register Bank

This block holds an 8-bit priority for every interrupt line and one priority-mask register for each CPU. Lines whose number is below the internal-line count keep a private priority copy per CPU. All higher-numbered lines share a single copy. A synchronous access port reads and writes these registers. Each access carries a target kind (line priority or own-CPU mask), a line index, the requesting CPU and a secure attribute. Read data comes back one cycle after the request.

When the security option is built in, a non-secure requester sees a compressed view. Its writes land in the upper half of the priority range as `0x80 | (w >> 1)`. Its reads return the stored value shifted left by one. Priorities of group-0 lines are hidden from it completely. The group of each line comes in on a per-line input vector. Only `PRIO_BITS` high-order priority bits exist, so every stored value and every read result has its low bits cleared. All stored values are also driven out in parallel, for use by a later arbitration stage.

Top module: `ipri_bank`

## Requirements
- R1: After reset, every priority copy, every mask register, `rsp_valid` and `rsp_rdata` are zero.
- R2: A read request (`req_valid`=1, `req_write`=0) raises `rsp_valid` on the next cycle with the read data. No response appears in any other cycle. A secure write stores the write data, which a later secure read returns, both limited to the implemented bits.
- R3: For a line index below `NUM_INTERNAL`, a write changes only the copy of the requesting CPU. Other CPUs keep their own value, both on reads and on `prio_out`.
- R4: For a line index at or above `NUM_INTERNAL`, one shared copy exists. A write by any CPU is seen by every CPU.
- R5: With the security option on, a non-secure priority write to a line whose `irq_group` bit is 0 changes nothing.
- R6: With the security option on, a non-secure priority write to a group-1 line stores `(0x80 | (w >> 1))` masked to the implemented bits.
- R7: With the security option on, a non-secure priority read returns 0 for a group-0 line. For a group-1 line it returns `(stored << 1) & 0xFF`, masked to the implemented bits.
- R8: The mask register of the requesting CPU is selected by `req_kind`=1. A secure write stores the masked data. A non-secure write is ignored while bit 7 of the current mask is 0. Otherwise it stores `(0x80 | (w >> 1))`, masked.
- R9: A non-secure mask read returns `(mask << 1) & 0xFF`, masked, when bit 7 of the mask is 1, and 0 otherwise.
- R10: With the security option off, `req_secure` has no effect and every access uses the raw view.
- R11: An access whose line index is `NUM_IRQ` or above does not change any stored value. Its read returns 0.
- R12: The low `8 - PRIO_BITS` bits of every stored value and of every read result are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_kind | input | 1 | 0 = line priority, 1 = requesting CPU's mask |
| req_idx | input | IDX_W | Line index for priority accesses |
| req_cpu | input | CPU_W | Requesting CPU |
| req_secure | input | 1 | Secure attribute of the access |
| req_wdata | input | 8 | Write data |
| irq_group | input | NUM_IRQ | Group bit per line (1 = group 1) |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 8 | Read data |
| prio_out | output | NUM_CPU*NUM_IRQ*8 | Stored priority per CPU and line, entry (c*NUM_IRQ+i) |
| pmask_out | output | NUM_CPU*8 | Stored mask per CPU |

## Verification
The hardest case is the non-secure mask write. It only takes effect once a secure write has first moved the mask into its upper half. Until then, non-secure traffic alone never gets past the bit-7 gate. The stimulus therefore runs two secure mask writes, one with bit 7 clear and one with bit 7 set, each followed by a non-secure write and reads in both views. The random phase mixes secure and non-secure accesses on the same CPU, so that both sides of the gate are reached repeatedly. A second instance, built without the security option and with a different implemented-bit count, receives the same stimulus.

// File: rtl/ipri_pkg.sv
package ipri_pkg;

    localparam int PRIO_W        = 8;
    localparam int PRIO_MAX_BITS = 8;
    localparam int PRIO_MIN_BITS = 4;
    localparam int VIRT_GRP_BITS = 5;

    typedef logic [PRIO_W-1:0] prio_t;

    typedef enum logic {
        TGT_PRIO = 1'b0,
        TGT_MASK = 1'b1
    } tgt_e;

    typedef struct packed {
        logic  prio_we;
        logic  mask_we;
        prio_t data;
    } wcmd_s;

    typedef struct packed {
        logic rd_any;
        logic rd_prio;
        logic rd_mask;
        logic ns;
        logic grp1;
    } rcmd_s;

    function automatic prio_t impl_mask(int bits);
        return prio_t'(8'hFF << (PRIO_MAX_BITS - bits));
    endfunction

    function automatic prio_t ns_down(prio_t v);
        return prio_t'(8'h80 | (v >> 1));
    endfunction

    function automatic prio_t ns_up(prio_t v);
        return {v[PRIO_W-2:0], 1'b0};
    endfunction

endpackage

// File: rtl/ipri_decode.sv
module ipri_decode
    import ipri_pkg::*;
#(
    parameter int NUM_IRQ   = 64,
    parameter int NUM_CPU   = 2,
    parameter int IDX_W     = 7,
    parameter int CPU_W     = 1,
    parameter int PRIO_BITS = 5,
    parameter bit SEC_EXT   = 1'b1
) (
    input  logic               req_valid,
    input  logic               req_write,
    input  tgt_e               req_kind,
    input  logic [IDX_W-1:0]   req_idx,
    input  logic [CPU_W-1:0]   req_cpu,
    input  logic               req_secure,
    input  prio_t              req_wdata,
    input  logic [NUM_IRQ-1:0] irq_group,
    input  prio_t              cur_mask,
    output wcmd_s              wcmd,
    output rcmd_s              rcmd
);

    localparam prio_t IMPL = impl_mask(PRIO_BITS);

    logic idx_ok;
    logic cpu_ok;
    logic ns;
    logic grp1;
    logic wr_go;
    logic rd_go;

    always_comb begin
        grp1 = 1'b0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (req_idx == IDX_W'(i)) grp1 = irq_group[i];
        end
    end

    assign idx_ok = int'(req_idx) < NUM_IRQ;
    assign cpu_ok = int'(req_cpu) < NUM_CPU;
    assign ns     = SEC_EXT && !req_secure;
    assign wr_go  = req_valid && req_write && cpu_ok;
    assign rd_go  = req_valid && !req_write && cpu_ok;

    always_comb begin
        wcmd.prio_we = wr_go && (req_kind == TGT_PRIO) && idx_ok && (!ns || grp1);
        wcmd.mask_we = wr_go && (req_kind == TGT_MASK) && (!ns || cur_mask[PRIO_W-1]);
        wcmd.data    = (ns ? ns_down(req_wdata) : req_wdata) & IMPL;

        rcmd.rd_any  = req_valid && !req_write;
        rcmd.rd_prio = rd_go && (req_kind == TGT_PRIO) && idx_ok;
        rcmd.rd_mask = rd_go && (req_kind == TGT_MASK);
        rcmd.ns      = ns;
        rcmd.grp1    = grp1;
    end

endmodule

// File: rtl/ipri_store.sv
module ipri_store
    import ipri_pkg::*;
#(
    parameter int NUM_IRQ      = 64,
    parameter int NUM_INTERNAL = 32,
    parameter int NUM_CPU      = 2,
    parameter int IDX_W        = 7,
    parameter int CPU_W        = 1
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              we,
    input  logic [IDX_W-1:0]                  idx,
    input  logic [CPU_W-1:0]                  cpu,
    input  prio_t                             wdata,
    output prio_t                             rd_raw,
    output logic [NUM_CPU*NUM_IRQ*PRIO_W-1:0] view_flat
);

    prio_t view [NUM_CPU][NUM_IRQ];

    for (genvar gi = 0; gi < NUM_IRQ; gi++) begin : g_irq
        if (gi < NUM_INTERNAL) begin : g_bank
            for (genvar gc = 0; gc < NUM_CPU; gc++) begin : g_cpu
                prio_t q;
                always_ff @(posedge clk) begin
                    if (rst) begin
                        q <= '0;
                    end else if (we && idx == IDX_W'(gi) && cpu == CPU_W'(gc)) begin
                        q <= wdata;
                    end
                end
                assign view[gc][gi] = q;
            end
        end else begin : g_shr
            prio_t q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= '0;
                end else if (we && idx == IDX_W'(gi)) begin
                    q <= wdata;
                end
            end
            for (genvar gc = 0; gc < NUM_CPU; gc++) begin : g_fan
                assign view[gc][gi] = q;
            end
        end
    end

    always_comb begin
        rd_raw = '0;
        for (int c = 0; c < NUM_CPU; c++) begin
            for (int i = 0; i < NUM_IRQ; i++) begin
                if (cpu == CPU_W'(c) && idx == IDX_W'(i)) rd_raw = view[c][i];
            end
        end
    end

    always_comb begin
        for (int c = 0; c < NUM_CPU; c++) begin
            for (int i = 0; i < NUM_IRQ; i++) begin
                view_flat[(c*NUM_IRQ+i)*PRIO_W +: PRIO_W] = view[c][i];
            end
        end
    end

endmodule

// File: rtl/ipri_pmask.sv
module ipri_pmask
    import ipri_pkg::*;
#(
    parameter int NUM_CPU = 2,
    parameter int CPU_W   = 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  logic [CPU_W-1:0]          cpu,
    input  prio_t                     wdata,
    output prio_t                     cur,
    output logic [NUM_CPU*PRIO_W-1:0] mask_flat
);

    prio_t regs [NUM_CPU];

    for (genvar gc = 0; gc < NUM_CPU; gc++) begin : g_cpu
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[gc] <= '0;
            end else if (we && cpu == CPU_W'(gc)) begin
                regs[gc] <= wdata;
            end
        end
        assign mask_flat[gc*PRIO_W +: PRIO_W] = regs[gc];
    end

    always_comb begin
        cur = '0;
        for (int c = 0; c < NUM_CPU; c++) begin
            if (cpu == CPU_W'(c)) cur = regs[c];
        end
    end

endmodule

// File: rtl/ipri_rdview.sv
module ipri_rdview
    import ipri_pkg::*;
#(
    parameter int PRIO_BITS = 5
) (
    input  logic  clk,
    input  logic  rst,
    input  rcmd_s rcmd,
    input  prio_t raw_prio,
    input  prio_t raw_mask,
    output logic  rsp_valid,
    output prio_t rsp_rdata
);

    localparam prio_t IMPL = impl_mask(PRIO_BITS);

    prio_t vis;

    always_comb begin
        vis = '0;
        if (rcmd.rd_prio) begin
            if (!rcmd.ns)       vis = raw_prio;
            else if (rcmd.grp1) vis = ns_up(raw_prio);
        end else if (rcmd.rd_mask) begin
            if (!rcmd.ns)                vis = raw_mask;
            else if (raw_mask[PRIO_W-1]) vis = ns_up(raw_mask);
        end
        vis = vis & IMPL;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rcmd.rd_any;
            rsp_rdata <= vis;
        end
    end

endmodule

// File: rtl/ipri_bank.sv
module ipri_bank
    import ipri_pkg::*;
#(
    parameter int NUM_IRQ      = 64,
    parameter int NUM_INTERNAL = 32,
    parameter int NUM_CPU      = 2,
    parameter int IDX_W        = 7,
    parameter int PRIO_BITS    = 5,
    parameter bit SEC_EXT      = 1'b1,
    parameter bit VIRT_EXT     = 1'b0,
    localparam int CPU_W       = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              req_valid,
    input  logic                              req_write,
    input  logic                              req_kind,
    input  logic [IDX_W-1:0]                  req_idx,
    input  logic [CPU_W-1:0]                  req_cpu,
    input  logic                              req_secure,
    input  logic [7:0]                        req_wdata,
    input  logic [NUM_IRQ-1:0]                irq_group,
    output logic                              rsp_valid,
    output logic [7:0]                        rsp_rdata,
    output logic [NUM_CPU*NUM_IRQ*8-1:0]      prio_out,
    output logic [NUM_CPU*8-1:0]              pmask_out
);

    wcmd_s wcmd;
    rcmd_s rcmd;
    prio_t cur_mask;
    prio_t raw_prio;

    ipri_decode #(
        .NUM_IRQ   (NUM_IRQ),
        .NUM_CPU   (NUM_CPU),
        .IDX_W     (IDX_W),
        .CPU_W     (CPU_W),
        .PRIO_BITS (PRIO_BITS),
        .SEC_EXT   (SEC_EXT)
    ) u_decode (
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_kind   (tgt_e'(req_kind)),
        .req_idx    (req_idx),
        .req_cpu    (req_cpu),
        .req_secure (req_secure),
        .req_wdata  (req_wdata),
        .irq_group  (irq_group),
        .cur_mask   (cur_mask),
        .wcmd       (wcmd),
        .rcmd       (rcmd)
    );

    ipri_store #(
        .NUM_IRQ      (NUM_IRQ),
        .NUM_INTERNAL (NUM_INTERNAL),
        .NUM_CPU      (NUM_CPU),
        .IDX_W        (IDX_W),
        .CPU_W        (CPU_W)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .we        (wcmd.prio_we),
        .idx       (req_idx),
        .cpu       (req_cpu),
        .wdata     (wcmd.data),
        .rd_raw    (raw_prio),
        .view_flat (prio_out)
    );

    ipri_pmask #(
        .NUM_CPU (NUM_CPU),
        .CPU_W   (CPU_W)
    ) u_pmask (
        .clk       (clk),
        .rst       (rst),
        .we        (wcmd.mask_we),
        .cpu       (req_cpu),
        .wdata     (wcmd.data),
        .cur       (cur_mask),
        .mask_flat (pmask_out)
    );

    ipri_rdview #(
        .PRIO_BITS (PRIO_BITS)
    ) u_rdview (
        .clk       (clk),
        .rst       (rst),
        .rcmd      (rcmd),
        .raw_prio  (raw_prio),
        .raw_mask  (cur_mask),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

endmodule

// File: rtl/ipri_bank_chk.sv
module ipri_bank_chk
    import ipri_pkg::*;
#(
    parameter int NUM_IRQ   = 64,
    parameter int NUM_CPU   = 2,
    parameter int IDX_W     = 7,
    parameter int CPU_W     = 1,
    parameter int PRIO_BITS = 5,
    parameter bit SEC_EXT   = 1'b1,
    parameter bit VIRT_EXT  = 1'b0
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         req_valid,
    input logic                         req_write,
    input logic                         req_kind,
    input logic [IDX_W-1:0]             req_idx,
    input logic [CPU_W-1:0]             req_cpu,
    input logic                         req_secure,
    input logic [NUM_IRQ-1:0]           irq_group,
    input logic                         rsp_valid,
    input logic [7:0]                   rsp_rdata,
    input logic [NUM_CPU*NUM_IRQ*8-1:0] prio_out,
    input logic [NUM_CPU*8-1:0]         pmask_out
);

    localparam prio_t IMPL     = impl_mask(PRIO_BITS);
    localparam int    MIN_BITS = VIRT_EXT ? VIRT_GRP_BITS : PRIO_MIN_BITS;

    logic sel_grp;
    logic sel_mask7;
    logic in_range;
    logic stray;
    logic ns_req;

    always_comb begin
        sel_grp = 1'b0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (req_idx == IDX_W'(i)) sel_grp = irq_group[i];
        end
        sel_mask7 = 1'b0;
        for (int c = 0; c < NUM_CPU; c++) begin
            if (req_cpu == CPU_W'(c)) sel_mask7 = pmask_out[c*8+7];
        end
        stray = 1'b0;
        for (int j = 0; j < NUM_CPU*NUM_IRQ; j++) begin
            stray = stray | (|(prio_out[j*8 +: 8] & ~IMPL));
        end
        for (int c = 0; c < NUM_CPU; c++) begin
            stray = stray | (|(pmask_out[c*8 +: 8] & ~IMPL));
        end
    end

    assign in_range = int'(req_idx) < NUM_IRQ;
    assign ns_req   = SEC_EXT && !req_secure;

    initial begin
        prio_bits_range_chk: assert (PRIO_BITS <= PRIO_MAX_BITS && PRIO_BITS >= MIN_BITS);
    end

    // R2
    rd_resp_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> rsp_valid);

    // R2
    no_spurious_resp_chk: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && !req_write) |=> !rsp_valid);

    // R12
    rd_low_bits_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ((rsp_rdata & ~IMPL) == 8'h00));

    // R12
    store_low_bits_chk: assert property (@(posedge clk) disable iff (rst)
        !stray);

    // R5
    ns_grp0_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && !req_kind && ns_req && in_range && !sel_grp)
        |=> $stable(prio_out));

    // R7
    ns_grp0_rd_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && !req_kind && ns_req && in_range && !sel_grp)
        |=> (rsp_rdata == 8'h00));

    // R8
    ns_mask_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_kind && ns_req && !sel_mask7)
        |=> $stable(pmask_out));

    // R11
    oor_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && !req_kind && !in_range)
        |=> $stable(prio_out));

endmodule

bind ipri_bank ipri_bank_chk #(
    .NUM_IRQ   (NUM_IRQ),
    .NUM_CPU   (NUM_CPU),
    .IDX_W     (IDX_W),
    .CPU_W     (CPU_W),
    .PRIO_BITS (PRIO_BITS),
    .SEC_EXT   (SEC_EXT),
    .VIRT_EXT  (VIRT_EXT)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_kind   (req_kind),
    .req_idx    (req_idx),
    .req_cpu    (req_cpu),
    .req_secure (req_secure),
    .irq_group  (irq_group),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .prio_out   (prio_out),
    .pmask_out  (pmask_out)
);

// File: tb/ipri_bank_bench.sv
`timescale 1ns/1ps
module ipri_bank_bench;

    localparam int NIRQ = 64;
    localparam int NINT = 32;
    localparam int NCPU = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic req_write = 1'b0;
    logic req_kind = 1'b0;
    logic [6:0] req_idx = '0;
    logic [0:0] req_cpu = '0;
    logic req_secure = 1'b1;
    logic [7:0] req_wdata = '0;
    logic [NIRQ-1:0] irq_group = '0;

    logic rv [2];
    logic [7:0] rd [2];
    logic [NCPU*NIRQ*8-1:0] po [2];
    logic [NCPU*8-1:0] pm [2];

    always #10 clk = ~clk;

    // instance 0: security on, 5 implemented bits
    ipri_bank #(.PRIO_BITS(5), .SEC_EXT(1'b1), .VIRT_EXT(1'b0)) u_ipri_bank (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_kind(req_kind), .req_idx(req_idx), .req_cpu(req_cpu),
        .req_secure(req_secure), .req_wdata(req_wdata), .irq_group(irq_group),
        .rsp_valid(rv[0]), .rsp_rdata(rd[0]), .prio_out(po[0]), .pmask_out(pm[0]));

    // instance 1: security off, 6 implemented bits
    ipri_bank #(.PRIO_BITS(6), .SEC_EXT(1'b0), .VIRT_EXT(1'b1)) u_ipri_bank_nosec (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_kind(req_kind), .req_idx(req_idx), .req_cpu(req_cpu),
        .req_secure(req_secure), .req_wdata(req_wdata), .irq_group(irq_group),
        .rsp_valid(rv[1]), .rsp_rdata(rd[1]), .prio_out(po[1]), .pmask_out(pm[1]));

    int total = 0;
    int bad = 0;
    bit done = 0;
    string cur_req = "R1";

    int cfg_sec [2] = '{1, 0};
    int cfg_bits [2] = '{5, 6};

    int mp [2][NCPU][NIRQ];
    int mm [2][NCPU];
    int erv [2];
    int erd [2];

    function automatic int imask(int n);
        return (255 << (8 - n)) & 255;
    endfunction

    // reference model, updated on every rising edge
    always @(posedge clk) begin
        for (int k = 0; k < 2; k++) begin
            if (rst) begin
                for (int c = 0; c < NCPU; c++) begin
                    mm[k][c] = 0;
                    for (int i = 0; i < NIRQ; i++) mp[k][c][i] = 0;
                end
                erv[k] = 0;
                erd[k] = 0;
            end else begin
                int sec_eff, inr, g, idx, cpu, raw, v;
                sec_eff = (cfg_sec[k] == 0) || req_secure;
                idx = int'(req_idx);
                cpu = int'(req_cpu);
                inr = idx < NIRQ;
                g = inr ? int'(irq_group[req_idx[5:0]]) : 0;
                erv[k] = 0;
                erd[k] = 0;
                if (req_valid && !req_write) begin
                    erv[k] = 1;
                    if (!req_kind) begin
                        if (inr) begin
                            raw = mp[k][cpu][idx];
                            erd[k] = sec_eff ? raw : (g != 0 ? (raw << 1) & 255 : 0);
                        end
                    end else begin
                        raw = mm[k][cpu];
                        erd[k] = sec_eff ? raw : (((raw & 128) != 0) ? (raw << 1) & 255 : 0);
                    end
                    erd[k] = erd[k] & imask(cfg_bits[k]);
                end
                if (req_valid && req_write) begin
                    v = sec_eff ? int'(req_wdata) : (128 | (int'(req_wdata) >> 1));
                    v = v & imask(cfg_bits[k]);
                    if (!req_kind) begin
                        if (inr && (sec_eff || g != 0)) begin
                            if (idx < NINT) mp[k][cpu][idx] = v;
                            else for (int c = 0; c < NCPU; c++) mp[k][c][idx] = v;
                        end
                    end else if (sec_eff || (mm[k][cpu] & 128) != 0) begin
                        mm[k][cpu] = v;
                    end
                end
            end
        end
    end

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            for (int k = 0; k < 2; k++) begin
                bit ok;
                string what;
                int got, exp;
                ok = 1;
                got = 0;
                exp = 0;
                what = "";
                if (int'(rv[k]) != erv[k]) begin
                    ok = 0; what = "rsp_valid"; got = int'(rv[k]); exp = erv[k];
                end else if (rv[k] && int'(rd[k]) != erd[k]) begin
                    ok = 0; what = "rsp_rdata"; got = int'(rd[k]); exp = erd[k];
                end
                for (int c = 0; c < NCPU; c++) begin
                    if (ok && int'(pm[k][c*8 +: 8]) != mm[k][c]) begin
                        ok = 0; what = "pmask_out"; got = int'(pm[k][c*8 +: 8]); exp = mm[k][c];
                    end
                    for (int i = 0; i < NIRQ; i++) begin
                        if (ok && int'(po[k][(c*NIRQ+i)*8 +: 8]) != mp[k][c][i]) begin
                            ok = 0; what = "prio_out"; got = int'(po[k][(c*NIRQ+i)*8 +: 8]);
                            exp = mp[k][c][i];
                        end
                    end
                end
                total++;
                if (!ok) begin
                    bad++;
                    $display("FAIL %s inst%0d model %s: actual=%0h expected=%0h",
                             cur_req, k, what, got, exp);
                end
            end
        end
    end

    task automatic check(input int got, input int exp, input string tag, input string msg);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, msg, got, exp);
        end
    endtask

    // drive one access at a falling edge, return at the next falling edge
    task automatic op(input bit wr, input bit kind, input int idx, input int cpu,
                      input bit sec, input int wd);
        req_valid = 1'b1;
        req_write = wr;
        req_kind = kind;
        req_idx = 7'(idx);
        req_cpu = 1'(cpu);
        req_secure = sec;
        req_wdata = 8'(wd);
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    task automatic rd_chk(input bit kind, input int idx, input int cpu, input bit sec,
                          input int exp0, input int exp1, input string tag);
        op(1'b0, kind, idx, cpu, sec, 0);
        check(int'(rv[0]), 1, tag, "inst0 rsp_valid");
        check(int'(rd[0]), exp0, tag, "inst0 rsp_rdata");
        check(int'(rv[1]), 1, tag, "inst1 rsp_valid");
        check(int'(rd[1]), exp1, tag, "inst1 rsp_rdata");
    endtask

    task automatic finish_up;
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #4000000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_up();
    end

    initial begin
        logic [NCPU*NIRQ*8-1:0] snap0, snap1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        cur_req = "R1";
        check(int'(po[0] == '0), 1, "R1", "inst0 prio_out zero");
        check(int'(pm[0] == '0), 1, "R1", "inst0 pmask_out zero");
        check(int'(rv[0]), 0, "R1", "inst0 rsp_valid idle");
        rd_chk(1'b0, 3, 0, 1'b1, 0, 0, "R1");

        // R2 and R12: secure write and read, low bits dropped
        cur_req = "R2";
        op(1'b1, 1'b0, 5, 0, 1'b1, 8'hFF);
        check(int'(rv[0]), 0, "R2", "no response to write");
        rd_chk(1'b0, 5, 0, 1'b1, 8'hF8, 8'hFC, "R2");
        cur_req = "R12";
        op(1'b1, 1'b0, 9, 0, 1'b1, 8'h07);
        rd_chk(1'b0, 9, 0, 1'b1, 8'h00, 8'h04, "R12");

        // R3: banked copy per CPU
        cur_req = "R3";
        rd_chk(1'b0, 5, 1, 1'b1, 0, 0, "R3");
        op(1'b1, 1'b0, 5, 1, 1'b1, 8'h20);
        rd_chk(1'b0, 5, 0, 1'b1, 8'hF8, 8'hFC, "R3");
        check(int'(po[0][(1*NIRQ+5)*8 +: 8]), 8'h20, "R3", "inst0 cpu1 copy of line 5");

        // R4: shared copy
        cur_req = "R4";
        op(1'b1, 1'b0, 40, 1, 1'b1, 8'h5A);
        rd_chk(1'b0, 40, 0, 1'b1, 8'h58, 8'h58, "R4");
        check(int'(po[0][(0*NIRQ+40)*8 +: 8]), 8'h58, "R4", "inst0 cpu0 view of line 40");

        // group setup: line 7 and lines 40..63 are group 1
        irq_group = {{24{1'b1}}, 32'h0, 8'h80};
        @(negedge clk);

        // R5 / R10: non-secure write to group-0 line
        cur_req = "R5";
        op(1'b1, 1'b0, 6, 0, 1'b0, 8'h40);
        rd_chk(1'b0, 6, 0, 1'b1, 8'h00, 8'h40, "R5");

        // R6 / R10: non-secure write to group-1 line
        cur_req = "R6";
        op(1'b1, 1'b0, 7, 0, 1'b0, 8'h40);
        rd_chk(1'b0, 7, 0, 1'b1, 8'hA0, 8'h40, "R6");

        // R7 / R10: non-secure reads
        cur_req = "R7";
        rd_chk(1'b0, 7, 0, 1'b0, 8'h40, 8'h40, "R7");
        rd_chk(1'b0, 5, 0, 1'b0, 8'h00, 8'hFC, "R7");
        cur_req = "R10";
        rd_chk(1'b0, 6, 0, 1'b0, 8'h00, 8'h40, "R10");

        // R8 / R9: priority mask, lower half then upper half
        cur_req = "R8";
        op(1'b1, 1'b1, 0, 0, 1'b1, 8'h30);
        op(1'b1, 1'b1, 0, 0, 1'b0, 8'hFF);
        rd_chk(1'b1, 0, 0, 1'b1, 8'h30, 8'hFC, "R8");
        cur_req = "R9";
        rd_chk(1'b1, 0, 0, 1'b0, 8'h00, 8'hFC, "R9");
        cur_req = "R8";
        op(1'b1, 1'b1, 0, 0, 1'b1, 8'h90);
        op(1'b1, 1'b1, 0, 0, 1'b0, 8'h60);
        rd_chk(1'b1, 0, 0, 1'b1, 8'hB0, 8'h60, "R8");
        check(int'(pm[0][15:8]), 0, "R8", "cpu1 mask untouched");
        cur_req = "R9";
        rd_chk(1'b1, 0, 0, 1'b0, 8'h60, 8'h60, "R9");

        // R11: index past the last line
        cur_req = "R11";
        snap0 = po[0];
        snap1 = po[1];
        op(1'b1, 1'b0, 100, 0, 1'b1, 8'h77);
        op(1'b1, 1'b0, 64, 1, 1'b1, 8'hF0);
        check(int'(po[0] == snap0), 1, "R11", "inst0 prio_out unchanged");
        check(int'(po[1] == snap1), 1, "R11", "inst1 prio_out unchanged");
        rd_chk(1'b0, 100, 0, 1'b1, 0, 0, "R11");

        // R12 with mixed random traffic, compared to the model each cycle
        cur_req = "R12";
        for (int n = 0; n < 3000; n++) begin
            if (n % 200 == 0) irq_group = {$urandom, $urandom};
            if ($urandom_range(0, 3) == 0) begin
                @(negedge clk);
            end else begin
                op(1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0),
                   int'($urandom_range(0, 70)), int'($urandom_range(0, 1)),
                   1'($urandom_range(0, 1)), int'($urandom_range(0, 255)));
            end
        end

        @(negedge clk);
        finish_up();
    end

endmodule